// File: doc/BRIEF.md
# System Protection Watchdog and Bus Monitor

This unit guards a processor subsystem with two independent timers behind a two-location register interface. A software watchdog counts system clocks while it is enabled. Software restarts the count with an ordered two-value key written to a service location. If the count reaches its programmed timeout, the unit raises a one-cycle reset request, records the cause, and returns its own state to the reset condition. A halt monitor can also raise the reset request when the processor reports that it has halted. A bus monitor counts clocks during every bus cycle that has not yet been acknowledged, and raises a bus error when the programmed limit is reached.

All of this is configured by one control byte. After any reset the control byte accepts a single write; every later write is ignored until the next reset. A cause register holds one flag for each reset source the unit sees. Power-on and external resets come from outside. Watchdog and halt-monitor resets are produced by the unit itself.

Top module: `sys_guard`

## Requirements
- R1: A write with `reg_sel`=0 loads `reg_wdata` into the control byte only if this is the first control write since the last reset (power-on, external or self-generated). Later writes leave `ctrl_byte` unchanged. The reset value is `CTRL_INIT` (0x00 by default).
- R2: Control byte fields: bit 7 enables the watchdog; bit 6 selects the watchdog prescaler; bits 5:4 (`s`) select the watchdog timeout; bit 3 enables the halt monitor; bit 2 enables monitoring of external bus cycles; bits 1:0 (`b`) select the bus monitor limit.
- R3: While the watchdog is enabled, `rst_req` is high for exactly one cycle once 2^(WD_BASE_LOG2 + WD_STEP_LOG2·s) clocks have elapsed since the last restart, multiplied by 2^WD_PRE_LOG2 when bit 6 is set. The count restarts when the watchdog becomes enabled. Defaults: 2^9, 2^11, 2^13, 2^15, with prescale ×512.
- R4: A write of 0x55 with `reg_sel`=1, followed by a write of 0xAA with `reg_sel`=1, restarts the watchdog count at the 0xAA write.
- R5: After 0x55, a service write of any value other than 0xAA leaves the key waiting for 0xAA. While the key is idle, a service write of any value other than 0x55 is ignored and does not restart the count.
- R6: While bit 7 is clear, the watchdog count is held at zero and never requests a reset.
- R7: `cause_flags` bit 7 marks an external reset, bit 6 power-on, bit 5 watchdog expiry and bit 4 halt-monitor reset. Bits 3:0 read zero. Each reset event replaces the whole register. Power-on and external resets take precedence over the unit's own trips in the same cycle.
- R8: A watchdog or halt-monitor trip returns the control byte to `CTRL_INIT`, unlocks it, idles the key and clears both timers.
- R9: With bit 3 set, a high `cpu_halt` sampled at a clock edge raises `rst_req` and sets cause bit 4.
- R10: The bus monitor counts each edge at which `bus_cycle` is high and `bus_ack` is low. After 2^(BM_MAX_LOG2−b) such edges (64, 32, 16, 8 by default), `bus_err` rises and stays high until the cycle is acknowledged or ends.
- R11: A cycle with `bus_ext` high is monitored only while bit 2 is set. Otherwise it never raises `bus_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| ext_rst | input | 1 | External reset, synchronous, active high |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control byte, 1 = service key |
| reg_wdata | input | 8 | Write data |
| bus_cycle | input | 1 | A bus cycle is in progress |
| bus_ext | input | 1 | The current cycle targets external space |
| bus_ack | input | 1 | Transfer acknowledge |
| cpu_halt | input | 1 | Processor reports a halted state |
| ctrl_byte | output | 8 | Current control byte |
| cause_flags | output | 8 | Reset cause flags |
| rst_req | output | 1 | One-cycle reset request |
| bus_err | output | 1 | Bus error for an unterminated cycle |

## Verification
The bench builds the unit with WD_BASE_LOG2=4, WD_STEP_LOG2=2, WD_PRE_LOG2=3 and BM_MAX_LOG2=4. With these values the four watchdog timeouts are 16, 64, 256 and 1024 clocks, and the prescaled path multiplies them by 8. Every timeout select and the prescaler can therefore be driven to expiry within a few thousand cycles, with an exact count for each. The bus monitor limits become 16, 8, 4 and 2 clocks, so both the saturated error level and a cycle acknowledged just before its limit are reached quickly.

// File: rtl/sg_pkg.sv
package sg_pkg;

    typedef struct packed {
        logic       wd_en;
        logic       wd_pre;
        logic [1:0] wd_sel;
        logic       hlt_en;
        logic       bm_ext_en;
        logic [1:0] bm_sel;
    } guard_ctrl_t;

    typedef enum logic {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } key_state_t;

    localparam logic       SEL_CTRL = 1'b0;
    localparam logic       SEL_SVC  = 1'b1;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    localparam int CAUSE_EXT = 7;
    localparam int CAUSE_POR = 6;
    localparam int CAUSE_WDT = 5;
    localparam int CAUSE_HLT = 4;

    function automatic int wd_shift(input int base, input int step, input int pre,
                                    input logic use_pre, input logic [1:0] sel);
        return base + step * int'(sel) + (use_pre ? pre : 0);
    endfunction

    function automatic int bm_shift(input int max_log2, input logic [1:0] sel);
        return max_log2 - int'(sel);
    endfunction

endpackage

// File: rtl/sg_ctrl_reg.sv
module sg_ctrl_reg
    import sg_pkg::*;
#(
    parameter logic [7:0] CTRL_INIT = 8'h00
) (
    input  logic        clk,
    input  logic        clr,
    input  logic        we,
    input  logic [7:0]  wdata,
    output guard_ctrl_t ctrl_o,
    output logic        locked_o
);

    guard_ctrl_t ctrl_q;
    logic        lock_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            ctrl_q <= guard_ctrl_t'(CTRL_INIT);
            lock_q <= 1'b0;
        end else if (we && !lock_q) begin
            ctrl_q <= guard_ctrl_t'(wdata);
            lock_q <= 1'b1;
        end
    end

    assign ctrl_o   = ctrl_q;
    assign locked_o = lock_q;

endmodule

// File: rtl/sg_wdt.sv
module sg_wdt
    import sg_pkg::*;
#(
    parameter int BASE_LOG2 = 9,
    parameter int STEP_LOG2 = 2,
    parameter int PRE_LOG2  = 9
) (
    input  logic       clk,
    input  logic       clr,
    input  logic       en,
    input  logic       use_pre,
    input  logic [1:0] sel,
    input  logic       svc_we,
    input  logic [7:0] svc_data,
    output logic       expire_o
);

    localparam int CNT_W = BASE_LOG2 + 3 * STEP_LOG2 + PRE_LOG2;

    key_state_t       key_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_nx;
    logic [CNT_W:0]   limit;
    logic             svc_done;

    always_comb begin
        limit    = {{CNT_W{1'b0}}, 1'b1} << wd_shift(BASE_LOG2, STEP_LOG2, PRE_LOG2, use_pre, sel);
        cnt_nx   = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
        svc_done = svc_we && (key_q == KEY_ARMED) && (svc_data == KEY_SECOND);
        expire_o = en && (cnt_nx >= limit);
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            key_q <= KEY_IDLE;
            cnt_q <= '0;
        end else begin
            if (svc_we) begin
                unique case (key_q)
                    KEY_IDLE:  if (svc_data == KEY_FIRST)  key_q <= KEY_ARMED;
                    KEY_ARMED: if (svc_data == KEY_SECOND) key_q <= KEY_IDLE;
                    default:   key_q <= KEY_IDLE;
                endcase
            end
            if (!en || svc_done) cnt_q <= '0;
            else                 cnt_q <= cnt_nx[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/sg_busmon.sv
module sg_busmon
    import sg_pkg::*;
#(
    parameter int MAX_LOG2 = 6
) (
    input  logic       clk,
    input  logic       clr,
    input  logic       cyc,
    input  logic       ext,
    input  logic       ext_en,
    input  logic       ack,
    input  logic [1:0] sel,
    output logic       err_o
);

    localparam int W = MAX_LOG2 + 1;

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_nx;
    logic [W-1:0] limit;
    logic         watched;
    logic         hit;
    logic         err_q;

    always_comb begin
        limit   = {{(W-1){1'b0}}, 1'b1} << bm_shift(MAX_LOG2, sel);
        cnt_nx  = cnt_q + {{(W-1){1'b0}}, 1'b1};
        watched = cyc && (!ext || ext_en);
        hit     = cnt_nx >= limit;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q <= '0;
            err_q <= 1'b0;
        end else if (watched && !ack) begin
            cnt_q <= hit ? cnt_q : cnt_nx;
            err_q <= hit;
        end else begin
            cnt_q <= '0;
            err_q <= 1'b0;
        end
    end

    assign err_o = err_q;

endmodule

// File: rtl/sys_guard.sv
module sys_guard
    import sg_pkg::*;
#(
    parameter int         WD_BASE_LOG2 = 9,
    parameter int         WD_STEP_LOG2 = 2,
    parameter int         WD_PRE_LOG2  = 9,
    parameter int         BM_MAX_LOG2  = 6,
    parameter logic [7:0] CTRL_INIT    = 8'h00
) (
    input  logic       clk,
    input  logic       por,
    input  logic       ext_rst,
    input  logic       reg_we,
    input  logic       reg_sel,
    input  logic [7:0] reg_wdata,
    input  logic       bus_cycle,
    input  logic       bus_ext,
    input  logic       bus_ack,
    input  logic       cpu_halt,
    output logic [7:0] ctrl_byte,
    output logic [7:0] cause_flags,
    output logic       rst_req,
    output logic       bus_err
);

    guard_ctrl_t ctrl_q;
    logic        ctrl_locked;
    logic        wd_expire;
    logic        hlt_trip;
    logic        hard_rst;
    logic        self_trip;
    logic        clr_all;
    logic [7:0]  hard_cause;
    logic [7:0]  trip_cause;
    logic [7:0]  cause_q;
    logic        req_q;

    always_comb begin
        hlt_trip   = ctrl_q.hlt_en && cpu_halt;
        hard_rst   = por || ext_rst;
        self_trip  = wd_expire || hlt_trip;
        clr_all    = hard_rst || self_trip;
        hard_cause = '0;
        hard_cause[CAUSE_EXT] = ext_rst;
        hard_cause[CAUSE_POR] = por;
        trip_cause = '0;
        trip_cause[CAUSE_WDT] = wd_expire;
        trip_cause[CAUSE_HLT] = hlt_trip;
    end

    sg_ctrl_reg #(.CTRL_INIT(CTRL_INIT)) u_ctrl (
        .clk      (clk),
        .clr      (clr_all),
        .we       (reg_we && (reg_sel == SEL_CTRL)),
        .wdata    (reg_wdata),
        .ctrl_o   (ctrl_q),
        .locked_o (ctrl_locked)
    );

    sg_wdt #(
        .BASE_LOG2 (WD_BASE_LOG2),
        .STEP_LOG2 (WD_STEP_LOG2),
        .PRE_LOG2  (WD_PRE_LOG2)
    ) u_wdt (
        .clk      (clk),
        .clr      (clr_all),
        .en       (ctrl_q.wd_en),
        .use_pre  (ctrl_q.wd_pre),
        .sel      (ctrl_q.wd_sel),
        .svc_we   (reg_we && (reg_sel == SEL_SVC)),
        .svc_data (reg_wdata),
        .expire_o (wd_expire)
    );

    sg_busmon #(.MAX_LOG2(BM_MAX_LOG2)) u_bm (
        .clk    (clk),
        .clr    (clr_all),
        .cyc    (bus_cycle),
        .ext    (bus_ext),
        .ext_en (ctrl_q.bm_ext_en),
        .ack    (bus_ack),
        .sel    (ctrl_q.bm_sel),
        .err_o  (bus_err)
    );

    always_ff @(posedge clk) begin
        if (hard_rst) begin
            cause_q <= hard_cause;
            req_q   <= 1'b0;
        end else if (self_trip) begin
            cause_q <= trip_cause;
            req_q   <= 1'b1;
        end else begin
            req_q   <= 1'b0;
        end
    end

    assign ctrl_byte   = ctrl_q;
    assign cause_flags = cause_q;
    assign rst_req     = req_q;

endmodule

// File: rtl/sys_guard_chk.sv
module sys_guard_chk #(
    parameter logic [7:0] CTRL_INIT = 8'h00
) (
    input logic       clk,
    input logic       por,
    input logic       ext_rst,
    input logic       bus_cycle,
    input logic       bus_ext,
    input logic       bus_ack,
    input logic       cpu_halt,
    input logic       locked,
    input logic [7:0] ctrl_byte,
    input logic [7:0] cause_flags,
    input logic       rst_req,
    input logic       bus_err
);

    assert_lock_R1: assert property (@(posedge clk) disable iff (por)
        (locked && !ext_rst) |=> (rst_req || $stable(ctrl_byte)));

    assert_cause_R7: assert property (@(posedge clk) disable iff (por)
        rst_req |-> ((cause_flags[5] || cause_flags[4]) && cause_flags[7:6] == 2'b00));

    assert_quiet_R6: assert property (@(posedge clk) disable iff (por)
        (!ctrl_byte[7] && !(ctrl_byte[3] && cpu_halt)) |=> !rst_req);

    assert_unlock_R8: assert property (@(posedge clk) disable iff (por)
        rst_req |-> (!locked && ctrl_byte == CTRL_INIT));

    assert_halt_R9: assert property (@(posedge clk) disable iff (por)
        (ctrl_byte[3] && cpu_halt && !ext_rst) |=> (rst_req && cause_flags[4]));

    assert_pending_R10: assert property (@(posedge clk) disable iff (por)
        bus_err |-> $past(bus_cycle && !bus_ack));

    assert_extmask_R11: assert property (@(posedge clk) disable iff (por)
        (bus_cycle && bus_ext && !ctrl_byte[2]) |=> !bus_err);

endmodule

bind sys_guard sys_guard_chk #(.CTRL_INIT(CTRL_INIT)) u_chk (
    .clk         (clk),
    .por         (por),
    .ext_rst     (ext_rst),
    .bus_cycle   (bus_cycle),
    .bus_ext     (bus_ext),
    .bus_ack     (bus_ack),
    .cpu_halt    (cpu_halt),
    .locked      (ctrl_locked),
    .ctrl_byte   (ctrl_byte),
    .cause_flags (cause_flags),
    .rst_req     (rst_req),
    .bus_err     (bus_err)
);

// File: tb/sys_guard_bench.sv
`timescale 1ns/1ps
module sys_guard_bench;

    localparam int WB = 4;
    localparam int WS = 2;
    localparam int WP = 3;
    localparam int BM = 4;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       ext_rst = 1'b0;
    logic       reg_we = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic       bus_cycle = 1'b0;
    logic       bus_ext = 1'b0;
    logic       bus_ack = 1'b0;
    logic       cpu_halt = 1'b0;
    logic [7:0] ctrl_byte;
    logic [7:0] cause_flags;
    logic       rst_req;
    logic       bus_err;

    always #10 clk = ~clk;

    sys_guard #(
        .WD_BASE_LOG2 (WB),
        .WD_STEP_LOG2 (WS),
        .WD_PRE_LOG2  (WP),
        .BM_MAX_LOG2  (BM),
        .CTRL_INIT    (8'h00)
    ) u_sys_guard (
        .clk         (clk),
        .por         (por),
        .ext_rst     (ext_rst),
        .reg_we      (reg_we),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .bus_cycle   (bus_cycle),
        .bus_ext     (bus_ext),
        .bus_ack     (bus_ack),
        .cpu_halt    (cpu_halt),
        .ctrl_byte   (ctrl_byte),
        .cause_flags (cause_flags),
        .rst_req     (rst_req),
        .bus_err     (bus_err)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    logic [7:0] m_ctrl;
    logic [7:0] m_cause;
    bit  m_lock, m_arm, m_rreq, m_berr, m_valid;
    int  m_wd, m_bm, wl, bl;
    bit  tw, th, watched, done;

    task automatic model_clear();
        m_ctrl = 8'h00; m_lock = 0; m_arm = 0; m_wd = 0; m_bm = 0; m_berr = 0;
    endtask

    initial begin
        m_valid = 0;
        model_clear();
        m_cause = 8'h00;
        m_rreq = 0;
    end

    always @(posedge clk) begin
        cyc++;
        wl = 1 << (WB + WS * int'(m_ctrl[5:4]) + (m_ctrl[6] ? WP : 0));
        bl = 1 << (BM - int'(m_ctrl[1:0]));
        tw = m_ctrl[7] && (m_wd + 1 >= wl);
        th = m_ctrl[3] && cpu_halt;
        if (por || ext_rst) begin
            m_cause = (ext_rst ? 8'h80 : 8'h00) | (por ? 8'h40 : 8'h00);
            model_clear();
            m_rreq = 0;
            m_valid = 1;
        end else if (tw || th) begin
            m_cause = (tw ? 8'h20 : 8'h00) | (th ? 8'h10 : 8'h00);
            model_clear();
            m_rreq = 1;
        end else begin
            m_rreq = 0;
            watched = bus_cycle && (!bus_ext || m_ctrl[2]);
            if (watched && !bus_ack) begin
                if (m_bm + 1 >= bl) m_berr = 1;
                else begin m_bm++; m_berr = 0; end
            end else begin
                m_bm = 0; m_berr = 0;
            end
            done = reg_we && reg_sel && m_arm && (reg_wdata == 8'hAA);
            if (!m_ctrl[7] || done) m_wd = 0;
            else m_wd++;
            if (reg_we && reg_sel) begin
                if (!m_arm) begin
                    if (reg_wdata == 8'h55) m_arm = 1;
                end else if (reg_wdata == 8'hAA) m_arm = 0;
            end
            if (reg_we && !reg_sel && !m_lock) begin
                m_ctrl = reg_wdata;
                m_lock = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (m_valid && !finished) begin
            chk("R1 control byte vs model", {24'd0, ctrl_byte}, {24'd0, m_ctrl});
            chk("R3 reset request vs model", {31'd0, rst_req}, {31'd0, m_rreq});
            chk("R7 cause flags vs model", {24'd0, cause_flags}, {24'd0, m_cause});
            chk("R10 bus error vs model", {31'd0, bus_err}, {31'd0, m_berr});
        end
    end

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_req(output int at);
        int k = 0;
        while (!rst_req && k < 12000) begin
            @(negedge clk);
            k++;
        end
        at = cyc;
    endtask

    task automatic wait_err(output int at);
        int k = 0;
        while (!bus_err && k < 200) begin
            @(negedge clk);
            k++;
        end
        at = cyc;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected done");
            finished = 1;
            summary();
            $finish;
        end
    end

    initial begin
        int t0, at, seen;
        repeat (3) @(negedge clk);
        por = 1'b0;
        @(negedge clk);
        chk("R7 power-on cause", {24'd0, cause_flags}, 32'h40);
        chk("R1 reset value", {24'd0, ctrl_byte}, 32'h00);

        // one-shot lock, expiry without service
        wr(1'b0, 8'h80); t0 = cyc;
        wr(1'b0, 8'hB3);
        chk("R1 second write ignored", {24'd0, ctrl_byte}, 32'h80);
        wait_req(at);
        chk("R3 expiry after 16 clocks", at - t0, 16);
        chk("R7 watchdog cause", {24'd0, cause_flags}, 32'h20);
        @(negedge clk);
        chk("R8 control back to init", {24'd0, ctrl_byte}, 32'h00);
        chk("R3 request is one cycle", {31'd0, rst_req}, 32'd0);

        // correct service
        wr(1'b0, 8'h80);
        chk("R8 control writable after trip", {24'd0, ctrl_byte}, 32'h80);
        repeat (6) @(negedge clk);
        wr(1'b1, 8'h55);
        wr(1'b1, 8'hAA); t0 = cyc;
        wait_req(at);
        chk("R4 service restarts count", at - t0, 16);

        // broken key: 0x55, 0x12, 0x55, 0xAA
        wr(1'b0, 8'h80);
        wr(1'b1, 8'h55);
        wr(1'b1, 8'h12);
        wr(1'b1, 8'h55);
        wr(1'b1, 8'hAA); t0 = cyc;
        wait_req(at);
        chk("R5 key stays armed", at - t0, 16);

        // idle non-key writes ignored
        wr(1'b0, 8'h80); t0 = cyc;
        wr(1'b1, 8'hAA);
        wr(1'b1, 8'h33);
        wait_req(at);
        chk("R5 idle writes ignored", at - t0, 16);

        // timeout selects and prescale
        wr(1'b0, 8'h90); t0 = cyc;
        wait_req(at);
        chk("R2 select 1 gives 64", at - t0, 64);
        wr(1'b0, 8'hC0); t0 = cyc;
        wait_req(at);
        chk("R2 prescale gives 128", at - t0, 128);
        wr(1'b0, 8'hF0); t0 = cyc;
        wait_req(at);
        chk("R3 select 3 prescaled gives 8192", at - t0, 8192);

        // external reset
        @(negedge clk); ext_rst = 1'b1;
        @(negedge clk); ext_rst = 1'b0;
        chk("R7 external cause", {24'd0, cause_flags}, 32'h80);

        // watchdog disabled, halt and ext monitor enabled, bus limit 8
        wr(1'b0, 8'h0D);
        seen = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (rst_req) seen = 1;
        end
        chk("R6 disabled never requests", seen, 0);

        @(negedge clk); bus_cycle = 1'b1; bus_ext = 1'b0; t0 = cyc;
        wait_err(at);
        chk("R10 internal limit 8", at - t0, 8);
        repeat (3) @(negedge clk);
        chk("R10 error held while pending", {31'd0, bus_err}, 32'd1);
        bus_cycle = 1'b0;
        @(negedge clk);
        chk("R10 error clears at cycle end", {31'd0, bus_err}, 32'd0);

        bus_cycle = 1'b1; bus_ext = 1'b1; t0 = cyc;
        wait_err(at);
        chk("R11 external monitored when enabled", at - t0, 8);
        bus_cycle = 1'b0; bus_ext = 1'b0;
        @(negedge clk);

        seen = 0;
        bus_cycle = 1'b1;
        repeat (5) @(negedge clk);
        bus_ack = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0; bus_cycle = 1'b0;
        if (bus_err) seen = 1;
        repeat (10) begin
            @(negedge clk);
            if (bus_err) seen = 1;
        end
        chk("R10 acknowledged cycle no error", seen, 0);

        // halt monitor
        cpu_halt = 1'b1;
        @(negedge clk);
        cpu_halt = 1'b0;
        chk("R9 halt request", {31'd0, rst_req}, 32'd1);
        chk("R9 halt cause", {24'd0, cause_flags}, 32'h10);

        // external cycles unmonitored after trip (bit 2 clear)
        @(negedge clk);
        seen = 0;
        bus_cycle = 1'b1; bus_ext = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (bus_err) seen = 1;
        end
        chk("R11 external masked", seen, 0);
        bus_cycle = 1'b0; bus_ext = 1'b0;
        @(negedge clk);
        bus_cycle = 1'b1; t0 = cyc;
        wait_err(at);
        chk("R10 select 0 limit 16", at - t0, 16);
        bus_cycle = 1'b0;
        repeat (3) @(negedge clk);

        finished = 1;
        summary();
        $finish;
    end

endmodule